// File: doc/BRIEF.md
# Port Pin Edge-Capture Latch

This block watches a set of general-purpose input pins and records, for each pin on its own, the first level change after its capture latch is armed. Each pin passes through a synchronizer. A change in either direction then closes that pin's latch. The latch keeps the level the pin settled to after the change and raises the pin's status bit. Software reads the status and the held levels, and writes a mask to rearm latches. A one in the mask clears the status bit and reopens the latch. A zero does nothing.

While a latch is closed, further changes on the pin are not lost. They are remembered. When software reopens that latch, the pin is captured again on the very next clock, using the level it has at that moment. A separate readback always shows the synchronized live level of every pin, whether its latch is open or closed. After reset, a short warm-up window hides the settling of the synchronizer, so a pin that is high during reset does not report a phantom edge.

Top module: `port_edge_capture`

## Requirements
- R1: After reset every status bit is 0, every latch is open and `level_o` equals `live_o`.
- R2: `live_o[i]` shows `pin_i[i]` after SYNC_STAGES clock edges, whatever the state of latch i.
- R3: A rising or a falling change on a pin whose latch is open sets that pin's status bit (1 = captured).
- R4: While the status bit of pin i is 1 and it is not being cleared, `level_o[i]` holds the level the pin had just after the captured change.
- R5: While the status bit of pin i is 0, `level_o[i]` equals `live_o[i]`.
- R6: A cycle with `wr_en_i` high and `wr_data_i[i]` = 1 clears status bit i on the next clock and reopens latch i.
- R7: A bit of `wr_data_i` that is 0 leaves that pin's status, latch and held level unchanged.
- R8: Each pin's capture, hold and clear act on that pin alone.
- R9: If pin i changed while its latch was closed, then after a clear the status reads 0 for one cycle and is set again on the following clock. `level_o[i]` then holds the live level sampled at that moment, and the record of missed changes is emptied.
- R10: A pin that is at 1 through reset and stays there is not reported as changed once reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | NPINS | Command mask; a 1 clears and reopens, a 0 is ignored |
| stat_o | output | NPINS | Captured-change status per pin |
| level_o | output | NPINS | Held level when captured, live level when open |
| live_o | output | NPINS | Synchronized live level, bypassing the latch |

## Verification
The bench builds the block with NPINS = 6 and SYNC_STAGES = 3. Six pins are enough for a single vector to mix rising, falling, held, missed and untouched bits. The three-stage synchronizer lengthens the warm-up window, which makes the reset-time suppression measurable. A glitch of two changes, two cycles apart, checks the single-cycle zero status followed by recapture. A pin held high across reset confirms that no phantom capture appears once the warm-up ends.

// File: rtl/port_edge_capture_pkg.sv
package port_edge_capture_pkg;

    // Per-pin capture state
    typedef struct packed {
        logic closed;   // latch closed, status reads 1
        logic hold;     // level kept while closed
        logic missed;   // change seen while closed or during a clear
    } cap_state_t;

    localparam cap_state_t CAP_RESET = '{closed: 1'b0, hold: 1'b0, missed: 1'b0};

endpackage

// File: rtl/port_edge_sync.sv
module port_edge_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/port_edge_cell.sv
module port_edge_cell
    import port_edge_capture_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,     // synchronized level
    input  logic chg_i,     // qualified change this cycle
    input  logic clr_i,     // clear-and-reopen command
    output logic stat_o,
    output logic level_o
);

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            // reopen; a change in this cycle is kept for the recapture
            st_d.closed = 1'b0;
            st_d.missed = st_q.missed | chg_i;
        end else if (!st_q.closed) begin
            if (chg_i || st_q.missed) begin
                st_d.closed = 1'b1;
                st_d.hold   = lvl_i;
                st_d.missed = 1'b0;
            end
        end else if (chg_i) begin
            st_d.missed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= CAP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.closed;
    assign level_o = st_q.closed ? st_q.hold : lvl_i;

endmodule

// File: rtl/port_edge_capture.sv
module port_edge_capture #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_i,
    input  logic             wr_en_i,
    input  logic [NPINS-1:0] wr_data_i,
    output logic [NPINS-1:0] stat_o,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] live_o
);

    // Changes are ignored until synchronizer and previous-level flop hold real pin data
    localparam int WARM = SYNC_STAGES + 1;
    localparam int CW   = $clog2(WARM + 1);

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [CW-1:0]    warm;
    } top_state_t;

    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] chg;
    logic             armed;
    top_state_t       s_d, s_q;

    port_edge_sync #(
        .WIDTH (NPINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(pin_i),
        .sync_o (sync_lvl)
    );

    assign armed = (s_q.warm == CW'(WARM));

    always_comb begin
        s_d      = s_q;
        s_d.prev = sync_lvl;
        if (!armed) begin
            s_d.warm = s_q.warm + 1'b1;
        end
        chg = armed ? (sync_lvl ^ s_q.prev) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        port_edge_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (sync_lvl[i]),
            .chg_i  (chg[i]),
            .clr_i  (wr_en_i & wr_data_i[i]),
            .stat_o (stat_o[i]),
            .level_o(level_o[i])
        );
    end

    assign live_o = sync_lvl;

endmodule

// File: rtl/port_edge_capture_chk.sv
module port_edge_capture_chk #(
    parameter int NPINS = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [NPINS-1:0] wr_data_i,
    input logic [NPINS-1:0] stat_o,
    input logic [NPINS-1:0] level_o,
    input logic [NPINS-1:0] live_o
);

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R6: clear command drops the status on the next clock
        assert_clear_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && wr_data_i[i]) |=> !stat_o[i]);

        // R7: zero in the mask keeps a set status
        assert_zero_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && !wr_data_i[i] && stat_o[i]) |=> stat_o[i]);

        // R4: captured level is frozen while not cleared
        assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_o[i] && !(wr_en_i && wr_data_i[i])) |=> $stable(level_o[i]));

        // R5: open latch shows the live level
        assert_open_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !stat_o[i] |-> (level_o[i] == live_o[i]));
    end

endmodule

bind port_edge_capture port_edge_capture_chk #(.NPINS(NPINS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .stat_o   (stat_o),
    .level_o  (level_o),
    .live_o   (live_o)
);

// File: tb/test_port_edge_capture.sv
module test_port_edge_capture;

    localparam int N    = 6;
    localparam int SYNC = 3;
    localparam int NV   = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] stat, level, live;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    port_edge_capture #(.NPINS(N), .SYNC_STAGES(SYNC)) i_port_edge_capture (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .pin_i    (pins),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .stat_o   (stat),
        .level_o  (level),
        .live_o   (live)
    );

    typedef struct packed {
        logic [N-1:0] pins;
        logic         wr;
        logic [N-1:0] wdata;
        logic [N-1:0] stat;
        logic [N-1:0] lvl;
    } vec_t;

    // pins, write, mask, expected status, expected level
    localparam vec_t VEC [NV] = '{
        '{6'b000000, 1'b0, 6'b000000, 6'b000000, 6'b000000},  // idle
        '{6'b000101, 1'b0, 6'b000000, 6'b000101, 6'b000101},  // R3 rising
        '{6'b000001, 1'b0, 6'b000000, 6'b000101, 6'b000101},  // R4 bit2 falls while closed
        '{6'b000001, 1'b1, 6'b000001, 6'b000100, 6'b000101},  // R6 R8 clear bit0 only
        '{6'b000001, 1'b1, 6'b000100, 6'b000100, 6'b000001},  // R9 missed -> recapture at 0
        '{6'b000001, 1'b1, 6'b000000, 6'b000100, 6'b000001},  // R7 zero mask
        '{6'b110001, 1'b0, 6'b000000, 6'b110100, 6'b110001},  // R3 bits 4,5 rise
        '{6'b010001, 1'b1, 6'b100000, 6'b110100, 6'b010001},  // R3 falling capture after reopen
        '{6'b010001, 1'b1, 6'b111111, 6'b000000, 6'b010001},  // R6 clear all, R5 open
        '{6'b101110, 1'b0, 6'b000000, 6'b111111, 6'b101110}   // R3 every bit toggles
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [N-1:0] p);
        rst_n = 1'b0;
        pins  = p;
        wr_en = 1'b0;
        settle(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        do_reset('0);
        @(negedge clk);
        // R1 reset state
        check("R1 stat", stat, '0);
        check("R1 level", level, live);
        settle(SYNC + 3);

        for (int v = 0; v < NV; v++) begin
            pins    = VEC[v].pins;
            wr_en   = VEC[v].wr;
            wr_data = VEC[v].wdata;
            @(negedge clk);
            wr_en   = 1'b0;
            wr_data = '0;
            settle(SYNC + 3);
            check($sformatf("R3/R4/R6/R7/R9 stat v%0d", v), stat, VEC[v].stat);
            check($sformatf("R4/R5 level v%0d", v), level, VEC[v].lvl);
            check($sformatf("R2 live v%0d", v), live, VEC[v].pins);
        end

        // R10: pins high through reset give no capture
        do_reset('1);
        settle(SYNC + 6);
        check("R10 stat", stat, '0);
        check("R10 level", level, '1);
        check("R2 live after reset", live, '1);

        // R9: two changes on bit0, second one while closed
        pins[0] = 1'b0;
        settle(2);
        pins[0] = 1'b1;
        settle(SYNC + 4);
        check("R3 glitch fall captured", stat, 6'b000001);
        check("R4 glitch held 0", level, 6'b111110);
        wr_en   = 1'b1;
        wr_data = 6'b000001;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        check("R9 stat zero one cycle", stat, 6'b000000);
        @(negedge clk);
        check("R9 stat set again", stat, 6'b000001);
        check("R9 level recaptured", level, 6'b111111);
        // missed record emptied: clear again, stays open
        wr_en   = 1'b1;
        wr_data = 6'b000001;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        settle(3);
        check("R9 missed emptied", stat, 6'b000000);
        check("R8 other pins untouched", level, 6'b111111);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule